// File: doc/BRIEF.md
# UART FIFO Occupancy and Interrupt Status Controller

This block follows the fill levels of a 32-character receive queue and a 32-character transmit queue in a UART-style peripheral, and from those levels derives the status flags and interrupt bits that a host driver sees. It holds no character data. It keeps only an occupancy counter for each direction and a timer for characters that wait too long in the receive queue. The serializer, the baud generator and the storage arrays sit outside it and report to it through single-cycle strobes.

The receive side signals the host in one of two ways. A level interrupt fires once the receive queue is half full. A timeout interrupt fires when at least one character has waited for 32 bit periods with no new arrival and no host read. The transmit side requests more data while its queue holds half a queue or less. A write-only mask selects which raw interrupt bits reach the masked status and the single interrupt line. Flags and status follow a counter change in the same clock in which that counter is updated.

Top module: `uart_irq_status`

## Requirements
- R1: After a synchronous reset, both empty flags are 1, both full flags and busy are 0, the raw status is 3'b100 (only the transmit bit set), the mask is zero and the interrupt line is low.
- R2: Raw status bit 0 (receive level) is 1 while the receive occupancy is 16 or more and 0 while it is below 16. It rises on the push that brings the occupancy to 16 and falls on the read that brings it to 15.
- R3: Raw status bit 1 (receive timeout) goes to 1 once 32 bit-period ticks have arrived with the receive queue non-empty and no accepted push or read. An accepted push or read restarts the count and clears the bit. While the receive queue is empty the bit stays 0, whatever the ticks do.
- R4: Raw status bit 2 (transmit) is 1 while the transmit occupancy is 16 or less and 0 while it is above 16.
- R5: The receive-empty flag is 0 whenever one or more characters are held and returns to 1 on the read that removes the last one. The receive-full flag is 1 exactly when 32 characters are held.
- R6: The transmit-full flag is 1 exactly at 32 characters. The transmit-empty flag is 1 at zero occupancy. Busy is 1 while the transmit queue holds a character and drops on the drain that empties it.
- R7: A push into a full receive queue, a write into a full transmit queue, a read from an empty receive queue and a drain from an empty transmit queue change no occupancy.
- R8: A strobe on mask_we loads mask_wdata into the mask, which uses the same bit positions as the raw status. masked_irq equals raw_irq AND mask, and irq is the OR of the masked bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_push | input | 1 | A received character enters the receive queue |
| rx_read | input | 1 | The host reads one receive character |
| tx_write | input | 1 | The host writes one transmit character |
| tx_drain | input | 1 | The serializer takes one transmit character |
| bit_tick | input | 1 | One pulse per serial bit period |
| mask_we | input | 1 | Write strobe for the interrupt mask |
| mask_wdata | input | 3 | New mask value (bit 0 rx level, bit 1 rx timeout, bit 2 tx) |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue full |
| busy | output | 1 | Transmit side holds data |
| raw_irq | output | 3 | Raw interrupt status |
| masked_irq | output | 3 | Raw status gated by the mask |
| irq | output | 1 | OR of the masked bits |

## Verification
On every cycle the assertions check the local rules. The receive level bit can only rise after a push. An accepted read or push clears the timeout bit. An empty transmit queue always requests data. Busy falls only on a drain. The interrupt line never goes high without a raw cause. A full receive queue stays full under a push with no read. What only the directed scenarios show are the exact thresholds: the 15-to-16 transition in each direction, the 31st versus the 32nd tick, the count of reads needed to empty a queue after an overflow attempt, and the mask-selected combinations. These depend on cumulative counts that the bench computes from the requirements.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int QDEPTH_DEF  = 32;
    localparam int TIMEOUT_DEF = 32;

    // Raw/masked status layout: bit 0 rx level, bit 1 rx timeout, bit 2 tx.
    typedef struct packed {
        logic tx_req;
        logic rx_stale;
        logic rx_level;
    } irq_vec_t;

    typedef enum logic {
        DIR_RX = 1'b0,
        DIR_TX = 1'b1
    } qdir_e;

    function automatic int half_of(input int depth);
        return depth / 2;
    endfunction

endpackage

// File: rtl/occ_counter.sv
module occ_counter #(
    parameter int DEPTH = 32,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc,
    input  logic          dec,
    output logic [CW-1:0] level,
    output logic          full,
    output logic          empty,
    output logic          inc_ok,
    output logic          dec_ok
);
    localparam logic [CW-1:0] TOP = CW'(DEPTH);

    logic [CW-1:0] level_q;

    assign full   = (level_q == TOP);
    assign empty  = (level_q == '0);
    assign inc_ok = inc && !full;
    assign dec_ok = dec && !empty;
    assign level  = level_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= '0;
        end else if (inc_ok && !dec_ok) begin
            level_q <= level_q + 1'b1;
        end else if (dec_ok && !inc_ok) begin
            level_q <= level_q - 1'b1;
        end
    end
endmodule

// File: rtl/rx_stale_timer.sv
module rx_stale_timer #(
    parameter int LIMIT = 32,
    localparam int TW = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic holding,
    input  logic tick,
    output logic expired
);
    localparam logic [TW-1:0] LIM = TW'(LIMIT);

    logic [TW-1:0] ticks_q;

    always_ff @(posedge clk) begin
        if (rst || restart || !holding) begin
            ticks_q <= '0;
        end else if (tick && ticks_q != LIM) begin
            ticks_q <= ticks_q + 1'b1;
        end
    end

    assign expired = holding && (ticks_q == LIM);
endmodule

// File: rtl/irq_compose.sv
module irq_compose
    import uart_irq_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic [CW-1:0] rx_level,
    input  logic [CW-1:0] tx_level,
    input  logic          stale,
    input  irq_vec_t      mask,
    output irq_vec_t      raw,
    output irq_vec_t      gated,
    output logic          line
);
    localparam logic [CW-1:0] TRIG = CW'(half_of(DEPTH));

    always_comb begin
        raw.rx_level = (rx_level >= TRIG);
        raw.rx_stale = stale;
        raw.tx_req   = (tx_level <= TRIG);
        gated        = raw & mask;
        line         = |gated;
    end
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
    import uart_irq_pkg::*;
#(
    parameter int QDEPTH  = QDEPTH_DEF,
    parameter int TIMEOUT = TIMEOUT_DEF,
    localparam int CW = $clog2(QDEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_push,
    input  logic       rx_read,
    input  logic       tx_write,
    input  logic       tx_drain,
    input  logic       bit_tick,
    input  logic       mask_we,
    input  logic [2:0] mask_wdata,
    output logic       rx_empty,
    output logic       rx_full,
    output logic       tx_empty,
    output logic       tx_full,
    output logic       busy,
    output logic [2:0] raw_irq,
    output logic [2:0] masked_irq,
    output logic       irq
);
    logic [1:0]    up_v, down_v, full_v, empty_v, up_ok, down_ok;
    logic [CW-1:0] level_v [2];
    irq_vec_t      mask_q, raw_s, gated_s;
    logic          stale;

    assign up_v[DIR_RX]   = rx_push;
    assign down_v[DIR_RX] = rx_read;
    assign up_v[DIR_TX]   = tx_write;
    assign down_v[DIR_TX] = tx_drain;

    for (genvar d = 0; d < 2; d++) begin : g_queue
        occ_counter #(.DEPTH(QDEPTH)) u_occ (
            .clk    (clk),
            .rst    (rst),
            .inc    (up_v[d]),
            .dec    (down_v[d]),
            .level  (level_v[d]),
            .full   (full_v[d]),
            .empty  (empty_v[d]),
            .inc_ok (up_ok[d]),
            .dec_ok (down_ok[d])
        );
    end

    rx_stale_timer #(.LIMIT(TIMEOUT)) u_stale (
        .clk     (clk),
        .rst     (rst),
        .restart (up_ok[DIR_RX] || down_ok[DIR_RX]),
        .holding (!empty_v[DIR_RX]),
        .tick    (bit_tick),
        .expired (stale)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (mask_we) begin
            mask_q <= irq_vec_t'(mask_wdata);
        end
    end

    irq_compose #(.DEPTH(QDEPTH)) u_irq (
        .rx_level (level_v[DIR_RX]),
        .tx_level (level_v[DIR_TX]),
        .stale    (stale),
        .mask     (mask_q),
        .raw      (raw_s),
        .gated    (gated_s),
        .line     (irq)
    );

    assign rx_empty   = empty_v[DIR_RX];
    assign rx_full    = full_v[DIR_RX];
    assign tx_empty   = empty_v[DIR_TX];
    assign tx_full    = full_v[DIR_TX];
    assign busy       = !empty_v[DIR_TX];
    assign raw_irq    = raw_s;
    assign masked_irq = gated_s;
endmodule

// File: rtl/uart_irq_status_chk.sv
module uart_irq_status_chk (
    input logic       clk,
    input logic       rst,
    input logic       rx_push,
    input logic       rx_read,
    input logic       tx_drain,
    input logic       rx_empty,
    input logic       rx_full,
    input logic       tx_empty,
    input logic       busy,
    input logic [2:0] raw_irq,
    input logic       irq
);
    // R1
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rx_empty && tx_empty && !busy && raw_irq == 3'b100 && !irq));

    // R2
    a_r2_level_needs_push: assert property (@(posedge clk) disable iff (rst)
        $rose(raw_irq[0]) |-> $past(rx_push));

    // R3
    a_r3_read_clears_stale: assert property (@(posedge clk) disable iff (rst)
        ((rx_read && !rx_empty) || (rx_push && !rx_full)) |=> !raw_irq[1]);

    // R3
    a_r3_empty_not_stale: assert property (@(posedge clk) disable iff (rst)
        rx_empty |-> !raw_irq[1]);

    // R4
    a_r4_empty_tx_requests: assert property (@(posedge clk) disable iff (rst)
        tx_empty |-> raw_irq[2]);

    // R6
    a_r6_busy_falls_on_drain: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(tx_drain));

    // R7
    a_r7_full_holds: assert property (@(posedge clk) disable iff (rst)
        (rx_full && rx_push && !rx_read) |=> rx_full);

    // R8
    a_r8_line_has_cause: assert property (@(posedge clk) disable iff (rst)
        irq |-> (raw_irq != 3'b000));
endmodule

bind uart_irq_status uart_irq_status_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .rx_push  (rx_push),
    .rx_read  (rx_read),
    .tx_drain (tx_drain),
    .rx_empty (rx_empty),
    .rx_full  (rx_full),
    .tx_empty (tx_empty),
    .busy     (busy),
    .raw_irq  (raw_irq),
    .irq      (irq)
);

// File: tb/uart_irq_status_bench.sv
module uart_irq_status_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_push = 0, rx_read = 0, tx_write = 0, tx_drain = 0, bit_tick = 0;
    logic       mask_we = 0;
    logic [2:0] mask_wdata = '0;
    logic       rx_empty, rx_full, tx_empty, tx_full, busy, irq;
    logic [2:0] raw_irq, masked_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    uart_irq_status u_uart_irq_status (
        .clk(clk), .rst(rst), .rx_push(rx_push), .rx_read(rx_read),
        .tx_write(tx_write), .tx_drain(tx_drain), .bit_tick(bit_tick),
        .mask_we(mask_we), .mask_wdata(mask_wdata),
        .rx_empty(rx_empty), .rx_full(rx_full), .tx_empty(tx_empty),
        .tx_full(tx_full), .busy(busy), .raw_irq(raw_irq),
        .masked_irq(masked_irq), .irq(irq)
    );

    task automatic check(input string req, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    // Drive one cycle of strobes from a negedge; sample at the following negedge.
    task automatic step(input bit p, input bit r, input bit w, input bit d, input bit t);
        rx_push = p; rx_read = r; tx_write = w; tx_drain = d; bit_tick = t;
        @(negedge clk);
        rx_push = 0; rx_read = 0; tx_write = 0; tx_drain = 0; bit_tick = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
    endtask

    task automatic set_mask(input logic [2:0] m);
        mask_we = 1; mask_wdata = m;
        @(negedge clk);
        mask_we = 0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 rx_empty", rx_empty, 1);
        check("R1 tx_empty", tx_empty, 1);
        check("R1 rx_full", rx_full, 0);
        check("R1 busy", busy, 0);
        check("R1 raw_irq", raw_irq, 4);
        check("R1 irq", irq, 0);
    endtask

    task automatic t_rx_level();
        do_reset();
        step(1, 0, 0, 0, 0);
        check("R5 rx_empty after one push", rx_empty, 0);
        for (int i = 1; i < 15; i++) step(1, 0, 0, 0, 0);
        check("R2 level at 15", raw_irq[0], 0);
        step(1, 0, 0, 0, 0);
        check("R2 level at 16", raw_irq[0], 1);
        step(0, 1, 0, 0, 0);
        check("R2 level back to 15", raw_irq[0], 0);
    endtask

    task automatic t_rx_overflow();
        do_reset();
        for (int i = 0; i < 31; i++) step(1, 0, 0, 0, 0);
        check("R5 rx_full at 31", rx_full, 0);
        step(1, 0, 0, 0, 0);
        check("R5 rx_full at 32", rx_full, 1);
        step(1, 0, 0, 0, 0);
        check("R7 push into full", rx_full, 1);
        step(0, 1, 0, 0, 0);
        check("R7 one read after drop", rx_full, 0);
        for (int i = 0; i < 30; i++) step(0, 1, 0, 0, 0);
        check("R5 one left", rx_empty, 0);
        step(0, 1, 0, 0, 0);
        check("R5 last read", rx_empty, 1);
        step(0, 1, 0, 0, 0);
        check("R7 read from empty", rx_empty, 1);
        step(1, 0, 0, 0, 0);
        check("R7 no underflow", rx_empty, 0);
        step(0, 1, 0, 0, 0);
        check("R7 single char removed", rx_empty, 1);
    endtask

    task automatic t_timeout();
        do_reset();
        for (int i = 0; i < 40; i++) step(0, 0, 0, 0, 1);
        check("R3 empty ignores ticks", raw_irq[1], 0);
        step(1, 0, 0, 0, 0);
        for (int i = 0; i < 31; i++) step(0, 0, 0, 0, 1);
        check("R3 31 ticks", raw_irq[1], 0);
        step(0, 0, 0, 0, 1);
        check("R3 32 ticks", raw_irq[1], 1);
        step(1, 0, 0, 0, 0);
        check("R3 push restarts", raw_irq[1], 0);
        for (int i = 0; i < 32; i++) step(0, 0, 0, 0, 1);
        check("R3 expired again", raw_irq[1], 1);
        step(0, 1, 0, 0, 0);
        check("R3 read clears", raw_irq[1], 0);
        for (int i = 0; i < 32; i++) step(0, 0, 0, 0, 1);
        check("R3 remaining char expires", raw_irq[1], 1);
        step(0, 1, 0, 0, 0);
        check("R3 read to empty", raw_irq[1], 0);
        check("R5 empty after reads", rx_empty, 1);
    endtask

    task automatic t_tx();
        do_reset();
        for (int i = 0; i < 16; i++) step(0, 0, 1, 0, 0);
        check("R4 tx at 16", raw_irq[2], 1);
        check("R6 busy", busy, 1);
        step(0, 0, 1, 0, 0);
        check("R4 tx at 17", raw_irq[2], 0);
        step(0, 0, 0, 1, 0);
        check("R4 tx back to 16", raw_irq[2], 1);
        for (int i = 0; i < 16; i++) step(0, 0, 1, 0, 0);
        check("R6 tx_full", tx_full, 1);
        step(0, 0, 1, 0, 0);
        step(0, 0, 0, 1, 0);
        check("R7 write into full ignored", tx_full, 0);
        for (int i = 0; i < 30; i++) step(0, 0, 0, 1, 0);
        check("R6 one left busy", busy, 1);
        step(0, 0, 0, 1, 0);
        check("R6 tx_empty", tx_empty, 1);
        check("R6 busy clears", busy, 0);
        step(0, 0, 0, 1, 0);
        step(0, 0, 1, 0, 0);
        check("R7 drain from empty", tx_empty, 0);
    endtask

    task automatic t_mask();
        do_reset();
        set_mask(3'b111);
        check("R8 masked all", masked_irq, 4);
        check("R8 irq on", irq, 1);
        set_mask(3'b011);
        check("R8 tx masked off", masked_irq, 0);
        check("R8 irq off", irq, 0);
        for (int i = 0; i < 16; i++) step(1, 0, 0, 0, 0);
        check("R8 rx level passes", masked_irq, 1);
        check("R8 raw both", raw_irq, 5);
        set_mask(3'b100);
        check("R8 only tx", masked_irq, 4);
        check("R8 irq tx", irq, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_rx_level();
        t_rx_overflow();
        t_timeout();
        t_tx();
        t_mask();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule